// File: doc/BRIEF.md
# Byte-stepped I2C master controller

This block is a register-mapped I2C master that software steps through a transaction one byte at a time. It has four byte-wide registers: control, status, own address and data. Writing the status register with its start bit set sends a START condition followed by an address byte. After that, each byte moves when software writes the data register and then clears the pending flag through a control write. Writing status with the start bit clear ends the transaction with a STOP.

After every START or byte, the controller latches the received acknowledge into the status register. It then sets a sticky pending flag, which can drive an interrupt level. The bus-level signalling is delegated to a separate bit-level engine. The controller hands that engine one request per step (START, STOP, byte write or byte read) and waits for a single response.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, all four registers read 0x00, `irq` is low and no engine request is issued.
- R2: Register offsets are 0x00 control, 0x04 status, 0x08 own address and 0x0C data. Any other offset reads 0x00. The own-address register keeps only its low 7 bits. A status read always returns bit 5 as 0.
- R3: A control write never sets the pending bit (bit 4), and clears it when the written bit 4 is 0. Every other control bit takes the written value. Bit 7 enables ACK on received bytes and bit 5 enables the interrupt.
- R4: A status write replaces bits 7:4 only. Bits 3:0 keep their previous value.
- R5: A status write with bits 7, 5 and 4 set arms a START. Bits 7:6 select the mode: 11 is transmit and 10 is receive. The controller then issues request op 0 (START) with byte {data[7:1], NOT status[6]}.
- R6: In transmit mode with a transfer running, a control write that clears pending issues op 2 (WRITE) carrying the data register.
- R7: In receive mode the same control write issues op 3 (READ), with `eng_req_ack_en` equal to control bit 7. The returned byte is written into the data register.
- R8: When the response to a START, WRITE or READ arrives, status bit 0 becomes the inverse of the acknowledge and the pending bit is set. `irq` is high exactly while pending and interrupt-enable are both set.
- R9: A missing acknowledge ends the transfer. A later control write that clears pending issues no request.
- R10: With status bit 5 clear and a transfer running, the next step issues op 1 (STOP). Its response sets neither pending nor `irq` and ends the transfer.
- R11: No request is issued while pending is set, or while status bit 7 or bit 4 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| irq | output | 1 | Interrupt level |
| eng_req_valid | output | 1 | One-cycle request pulse to the bit engine |
| eng_req_op | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| eng_req_byte | output | 8 | Address or data byte |
| eng_req_ack_en | output | 1 | ACK the byte received on a READ |
| eng_resp_valid | input | 1 | Engine response pulse |
| eng_resp_ack | input | 1 | Slave acknowledged |
| eng_resp_byte | input | 8 | Byte received on a READ |

## Verification
Each fault in the internal state shows at the ports within one or two cycles of the software step that should have acted on it.
- A stuck transfer-running flag shows as an extra request, or a missing one, on the next pending-clear write.
- A lost armed-start flag shows as a missing START request, or one with the wrong opcode.
- A wrongly merged status nibble shows on the very next status read.
- A pending flag raised by a STOP shows on `irq` one cycle after the engine response.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int OWN_W  = BYTE_W - 1;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OWN  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA = 8'h0C;

  localparam int CB_ACKEN = 7;
  localparam int CB_IRQEN = 5;
  localparam int CB_PEND  = 4;

  localparam int SB_MASTER = 7;
  localparam int SB_TX     = 6;
  localparam int SB_START  = 5;
  localparam int SB_EN     = 4;
  localparam int SB_NACK   = 0;
endpackage

// File: rtl/i2c_bm_rst_sync.sv
module i2c_bm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              kick,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] stat_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              busy_o,
  output logic              armed_o,
  input  logic              take,
  input  logic              take_start,
  input  logic              fin_valid,
  input  logic              fin_stop,
  input  logic              fin_nack,
  input  logic              fin_read,
  input  logic [BYTE_W-1:0] fin_byte
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [OWN_W-1:0]  own_q, own_d;
  logic              busy_q, busy_d;
  logic              armed_q, armed_d;
  logic              upd_en;

  // Next-state logic: register writes first, then sequencer updates override.
  always_comb begin
    ctrl_d  = ctrl_q;
    stat_d  = stat_q;
    data_d  = data_q;
    own_d   = own_q;
    busy_d  = busy_q;
    armed_d = armed_q;
    kick    = 1'b0;
    if (wr) begin
      case (addr)
        OFS_CTRL: begin
          ctrl_d          = wdata;
          ctrl_d[CB_PEND] = ctrl_q[CB_PEND] & wdata[CB_PEND];
          kick            = busy_q | ~ctrl_d[CB_PEND];
        end
        OFS_STAT: begin
          stat_d = {wdata[BYTE_W-1:4], stat_q[3:0]};
          if (wdata[SB_START]) armed_d = 1'b1;
          kick = 1'b1;
        end
        OFS_OWN:  own_d = wdata[OWN_W-1:0];
        OFS_DATA: begin
          data_d = wdata;
          busy_d = 1'b1;
        end
        default: ;
      endcase
    end
    if (take) begin
      armed_d = 1'b0;
      if (take_start) busy_d = 1'b1;
    end
    if (fin_valid) begin
      if (fin_stop) begin
        busy_d = 1'b0;
      end else begin
        stat_d[SB_NACK] = fin_nack;
        if (fin_nack) busy_d = 1'b0;
        if (fin_read) data_d = fin_byte;
        ctrl_d[CB_PEND] = 1'b1;
      end
    end
  end

  assign upd_en = wr | take | fin_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      data_q  <= '0;
      own_q   <= '0;
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      data_q  <= data_d;
      own_q   <= own_d;
      busy_q  <= busy_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = ctrl_q;
      OFS_STAT: begin
        rdata           = stat_q;
        rdata[SB_START] = 1'b0;
      end
      OFS_OWN:  rdata = {1'b0, own_q};
      OFS_DATA: rdata = data_q;
      default:  rdata = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign stat_o  = stat_q;
  assign data_o  = data_q;
  assign busy_o  = busy_q;
  assign armed_o = armed_q;

  assert_pend_from_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[CB_PEND]) |-> $past(fin_valid && !fin_stop));

  assert_stat_low_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_STAT && !fin_valid) |=> (stat_q[3:0] == $past(stat_q[3:0])));

  assert_stop_no_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && fin_stop && !ctrl_q[CB_PEND]) |=> !ctrl_q[CB_PEND]);
endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [BYTE_W-1:0] ctrl_i,
  input  logic [BYTE_W-1:0] stat_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              busy_i,
  input  logic              armed_i,
  output logic              take,
  output logic              take_start,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [BYTE_W-1:0] req_byte,
  output logic              req_ack_en,
  input  logic              resp_valid,
  input  logic              resp_ack,
  input  logic [BYTE_W-1:0] resp_byte,
  output logic              fin_valid,
  output logic              fin_stop,
  output logic              fin_nack,
  output logic              fin_read,
  output logic [BYTE_W-1:0] fin_byte
);
  logic              kick_q;
  logic              wait_q, wait_d;
  op_e               op_q, op_sel;
  logic [BYTE_W-1:0] byte_sel;
  logic              master, eligible, start, go;

  always_comb begin
    master   = stat_i[SB_MASTER] & stat_i[SB_EN];
    eligible = kick_q & ~wait_q & ~ctrl_i[CB_PEND] & master;
    start    = armed_i & stat_i[SB_START];
    go       = eligible & (busy_i | start);
    if (start) begin
      op_sel   = OP_START;
      byte_sel = {data_i[BYTE_W-1:1], ~stat_i[SB_TX]};
    end else begin
      byte_sel = data_i;
      if (!stat_i[SB_START])  op_sel = OP_STOP;
      else if (stat_i[SB_TX]) op_sel = OP_WRITE;
      else                    op_sel = OP_READ;
    end
    fin_valid = wait_q & resp_valid;
    fin_stop  = (op_q == OP_STOP);
    fin_read  = (op_q == OP_READ);
    fin_nack  = ~resp_ack;
    fin_byte  = resp_byte;
    wait_d    = wait_q;
    if (go)             wait_d = 1'b1;
    else if (fin_valid) wait_d = 1'b0;
  end

  assign take       = eligible;
  assign take_start = eligible & start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_q    <= 1'b0;
      wait_q    <= 1'b0;
      req_valid <= 1'b0;
    end else begin
      kick_q    <= kick;
      wait_q    <= wait_d;
      req_valid <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_START;
      req_byte   <= '0;
      req_ack_en <= 1'b0;
    end else if (go) begin
      op_q       <= op_sel;
      req_byte   <= byte_sel;
      req_ack_en <= ctrl_i[CB_ACKEN];
    end
  end

  assign req_op = op_q;

  assert_req_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_req_needs_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(!ctrl_i[CB_PEND] && stat_i[SB_MASTER] && stat_i[SB_EN]));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              eng_req_valid,
  output logic [1:0]        eng_req_op,
  output logic [BYTE_W-1:0] eng_req_byte,
  output logic              eng_req_ack_en,
  input  logic              eng_resp_valid,
  input  logic              eng_resp_ack,
  input  logic [BYTE_W-1:0] eng_resp_byte
);
  logic              rst_n_s;
  logic              kick, take, take_start;
  logic [BYTE_W-1:0] ctrl, stat, data, fin_byte;
  logic              busy, armed;
  logic              fin_valid, fin_stop, fin_nack, fin_read;

  i2c_bm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  i2c_bm_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .kick(kick), .ctrl_o(ctrl), .stat_o(stat), .data_o(data),
    .busy_o(busy), .armed_o(armed), .take(take), .take_start(take_start),
    .fin_valid(fin_valid), .fin_stop(fin_stop), .fin_nack(fin_nack),
    .fin_read(fin_read), .fin_byte(fin_byte)
  );

  i2c_bm_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .kick(kick), .ctrl_i(ctrl), .stat_i(stat),
    .data_i(data), .busy_i(busy), .armed_i(armed), .take(take),
    .take_start(take_start), .req_valid(eng_req_valid), .req_op(eng_req_op),
    .req_byte(eng_req_byte), .req_ack_en(eng_req_ack_en),
    .resp_valid(eng_resp_valid), .resp_ack(eng_resp_ack), .resp_byte(eng_resp_byte),
    .fin_valid(fin_valid), .fin_stop(fin_stop), .fin_nack(fin_nack),
    .fin_read(fin_read), .fin_byte(fin_byte)
  );

  assign irq = ctrl[CB_PEND] & ctrl[CB_IRQEN];
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       eng_req_valid;
  logic [1:0] eng_req_op;
  logic [7:0] eng_req_byte;
  logic       eng_req_ack_en;
  logic       eng_resp_valid = 1'b0;
  logic       eng_resp_ack = 1'b0;
  logic [7:0] eng_resp_byte = 8'h00;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rv;

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_OWN = 8'h08, A_DATA = 8'h0C;

  always #5 clk = ~clk;

  i2c_byte_master dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_req(string tag, logic [1:0] op, logic [7:0] b, logic ae, bit chk_b);
    bit seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (eng_req_valid) begin
        seen = 1;
        chk({tag, " op"}, eng_req_op, op);
        if (chk_b) chk({tag, " byte"}, eng_req_byte, b);
        chk({tag, " ack_en"}, eng_req_ack_en, ae);
      end
    end
    chk({tag, " request seen"}, seen, 1);
  endtask

  task automatic expect_none(string tag);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (eng_req_valid) seen = 1;
    end
    chk({tag, " no request"}, seen, 0);
  endtask

  task automatic respond(logic ack, logic [7:0] b);
    @(negedge clk);
    eng_resp_valid = 1'b1; eng_resp_ack = ack; eng_resp_byte = b;
    @(negedge clk);
    eng_resp_valid = 1'b0;
  endtask

  function automatic logic [7:0] stat_view(logic [7:0] hi, logic nack);
    return {hi[7:6], 1'b0, hi[4], 3'b000, nack};
  endfunction

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h1c2b3a49);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 8'h00);
    rd(A_STAT, rv); chk("R1 stat", rv, 8'h00);
    rd(A_OWN, rv);  chk("R1 own", rv, 8'h00);
    rd(A_DATA, rv); chk("R1 data", rv, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 req", eng_req_valid, 0);

    // R2 map and width
    wr(A_OWN, 8'hFF); rd(A_OWN, rv); chk("R2 own 7 bits", rv, 8'h7F);
    rd(8'h10, rv); chk("R2 unmapped", rv, 8'h00);

    // R3 control write cannot set pending
    wr(A_CTRL, 8'hFF); rd(A_CTRL, rv); chk("R3 pend not set", rv, 8'hEF);
    wr(A_CTRL, 8'hA0);

    // R4 status write with zero low nibble kept
    wr(A_STAT, 8'h0F); rd(A_STAT, rv); chk("R4 low nibble kept", rv, 8'h00);

    // R11 not enabled: mode 11, start, enable clear
    wr(A_DATA, 8'h44); wr(A_STAT, 8'hE0); expect_none("R11 enable clear");

    // R5 START transmit
    wr(A_DATA, 8'hA5); wr(A_STAT, 8'hF0);
    expect_req("R5 start tx", 2'd0, 8'hA4, 1'b1, 1);
    respond(1'b1, 8'h00);
    rd(A_STAT, rv); chk("R8 stat after ack", rv, 8'hD0);
    rd(A_CTRL, rv); chk("R8 pend set", rv, 8'hB0);
    chk("R8 irq high", irq, 1);

    // R6 byte write
    wr(A_DATA, 8'h3C); wr(A_CTRL, 8'hA0);
    expect_req("R6 write byte", 2'd2, 8'h3C, 1'b1, 1);
    chk("R8 irq low after clear", irq, 0);
    respond(1'b1, 8'h00);
    chk("R8 irq after byte", irq, 1);

    // R11 stop blocked while pending, then R10 stop
    wr(A_STAT, 8'hD0); expect_none("R11 pending blocks");
    wr(A_CTRL, 8'h20);
    expect_req("R10 stop", 2'd1, 8'h00, 1'b0, 0);
    respond(1'b1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R10 no irq after stop", irq, 0);
    rd(A_CTRL, rv); chk("R10 no pend after stop", rv, 8'h20);
    wr(A_CTRL, 8'h20); expect_none("R10 transfer ended");

    // R7 receive
    wr(A_DATA, 8'h91); wr(A_STAT, 8'hB0);
    expect_req("R5 start rx", 2'd0, 8'h91, 1'b0, 1);
    respond(1'b1, 8'h00);
    wr(A_CTRL, 8'h20);
    expect_req("R7 read noack", 2'd3, 8'h00, 1'b0, 0);
    respond(1'b1, 8'h5E);
    rd(A_DATA, rv); chk("R7 data captured", rv, 8'h5E);
    wr(A_CTRL, 8'hA0);
    expect_req("R7 read ack", 2'd3, 8'h00, 1'b1, 0);
    respond(1'b1, 8'hC3);
    rd(A_DATA, rv); chk("R7 data captured 2", rv, 8'hC3);
    wr(A_STAT, 8'h90); wr(A_CTRL, 8'h20);
    expect_req("R10 stop rx", 2'd1, 8'h00, 1'b0, 0);
    respond(1'b1, 8'h00);

    // R9 nack on address
    wr(A_DATA, 8'h20); wr(A_STAT, 8'hF0);
    expect_req("R5 start nack", 2'd0, 8'h20, 1'b0, 1);
    respond(1'b0, 8'h00);
    rd(A_STAT, rv); chk("R8 nack bit", rv, 8'hD1);
    wr(A_CTRL, 8'h20); expect_none("R9 nack ends transfer");
    wr(A_STAT, 8'h0E); rd(A_STAT, rv); chk("R4 nack bit kept", rv, 8'h01);

    // random transactions
    for (int t = 0; t < 30; t++) begin
      logic       tx, a, alive, ae, ra;
      logic [7:0] d, sh, nd, rb;
      int         nb;
      tx = 1'($urandom % 2);
      d  = 8'($urandom);
      a  = 1'(($urandom % 4) != 0);
      nb = 1 + int'($urandom % 3);
      sh = tx ? 8'hF0 : 8'hB0;
      wr(A_DATA, d); wr(A_STAT, sh);
      expect_req("R5 rand start", 2'd0, {d[7:1], ~tx}, 1'b0, 1);
      respond(a, 8'h00);
      rd(A_STAT, rv); chk("R8 rand start status", rv, stat_view(sh, ~a));
      alive = a;
      for (int k = 0; k < nb; k++) begin
        if (alive) begin
          ae = 1'($urandom % 2);
          nd = 8'($urandom);
          rb = 8'($urandom);
          ra = tx ? 1'(($urandom % 4) != 0) : 1'b1;
          if (tx) wr(A_DATA, nd);
          wr(A_CTRL, {ae, 1'b0, 1'b1, 1'b0, 4'h0});
          if (tx) expect_req("R6 rand write", 2'd2, nd, ae, 1);
          else    expect_req("R7 rand read", 2'd3, 8'h00, ae, 0);
          respond(ra, rb);
          if (!tx) begin
            rd(A_DATA, rv); chk("R7 rand data", rv, rb);
          end
          rd(A_STAT, rv); chk("R8 rand byte status", rv, stat_view(sh, ~ra));
          chk("R8 rand irq", irq, 1);
          alive = ra;
        end
      end
      wr(A_STAT, sh & 8'hDF);
      wr(A_CTRL, 8'h20);
      if (alive) begin
        expect_req("R10 rand stop", 2'd1, 8'h00, 1'b0, 0);
        respond(1'b1, 8'h00);
        repeat (2) @(negedge clk);
        chk("R10 rand no irq", irq, 0);
      end else begin
        expect_none("R9 rand after nack");
      end
    end

    report();
    $finish;
  end
endmodule